// File: doc/BRIEF.md
# Descriptor Ring Channel Controller

This block runs one channel of a pair of rings shared with a host. One ring carries requests and the other carries responses. The host adds work by moving the request tail forward. The block then reads the element at the request head and hands its ID and command byte to an external executor. When the executor reports that the request is done, the block may post a response element at the response tail. Whether it posts one depends on a flag in the command byte. The block then moves the request head forward by one. The host collects responses by moving the response head forward.

All four ring indices are element indices, not byte offsets, and they wrap at the ring depth. They sit behind a small 32-bit register port. Each direction of travel has one owner: the host writes only the indices it owns. The block raises a single-cycle interrupt when a posted response makes an empty response ring non-empty. A request can force the interrupt by setting its force bit. Element fetch, bulk data movement, semaphores and doorbells lie outside the block. They appear only as the element inputs, the executor handshake and the response output.

Top module: `ring_chan_ctrl`

## Requirements
- R1: After reset, all four indices read 0, `exec_valid` and `rsp_valid` are low, and `irq` is low.
- R2: The register offsets are: request head at 0x0, request tail at 0x4, response head at 0x8, response tail at 0xc. A read returns the index zero-extended to 32 bits. A host write to 0x4 or 0x8 keeps only the low log2(RING_DEPTH) bits.
- R3: Host writes to offset 0x0 (request head) and offset 0xc (response tail) have no effect.
- R4: While the request head differs from the request tail, the block takes the element at index `ring_rd_idx`, which equals the request head. It offers that element on `exec_valid`/`exec_id`/`exec_cmd`. Only one request is in flight at a time.
- R5: The request head advances by exactly one when a request finishes, wrapping at RING_DEPTH.
- R6: The block posts a response only when command bit 4 is 1. The response carries the request ID and the code taken from `done_code` (0 means success) at slot `rsp_slot`, which equals the response tail. The response tail then advances by one, with wrap.
- R7: A command whose bits 1:0 equal 3 is never offered to the executor. It completes with code 0x0003 and still follows R6. Bit 3 (bulk) and direction values 1 and 2 pass through unchanged on `exec_cmd`.
- R8: `irq` pulses for exactly one cycle after a response is posted into a response ring that was empty at that moment (head equal to tail). Posting into a non-empty ring gives no pulse.
- R9: A request with command bit 7 set produces one `irq` pulse when it completes. This holds whatever the ring state and whether or not a response is posted.
- R10: The response ring is full when tail+1 equals head modulo RING_DEPTH. While the ring is full, `rsp_valid` stays low. Posting resumes after the host advances the response head.
- R11: Once `rsp_valid` is high, it stays high with `rsp_id`, `rsp_code` and `rsp_slot` unchanged until `rsp_ready` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Host register write strobe |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 32 | Host write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| ring_rd_idx | output | IDXW | Request element index being examined (request head) |
| elem_id | input | 16 | Request ID of the element at `ring_rd_idx` |
| elem_cmd | input | 8 | Command byte of the element at `ring_rd_idx` |
| exec_valid | output | 1 | Request offered to executor |
| exec_ready | input | 1 | Executor accepts the request |
| exec_id | output | 16 | Offered request ID |
| exec_cmd | output | 8 | Offered command byte |
| done_valid | input | 1 | Executor finished the accepted request |
| done_code | input | 16 | Completion code from executor |
| rsp_valid | output | 1 | Response element ready to be written |
| rsp_ready | input | 1 | Response element accepted |
| rsp_slot | output | IDXW | Response ring index to write |
| rsp_id | output | 16 | Response request ID |
| rsp_code | output | 16 | Response completion code |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The checker relies on a few host and executor habits. The host moves the response head only over entries that have already been posted, so the ring never looks full while a response is held. The executor raises `done_valid` only after it has accepted a request. The stimulus keeps to both: it writes the response head only with the tracked response tail or one step past the tracked head. It also drives `done_valid` for exactly one cycle after each accept handshake. Request tail writes always step one past the previous value and never run the ring over.

// File: rtl/ring_chan_pkg.sv
package ring_chan_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_EXEC = 2'd1,
    ST_WAIT = 2'd2,
    ST_POST = 2'd3
  } seq_st_e;

  // command byte bit positions
  localparam int unsigned CMD_FORCE_IRQ = 7;
  localparam int unsigned CMD_WANT_RSP  = 4;

  localparam logic [1:0]  DIR_ILLEGAL   = 2'd3;
  localparam logic [15:0] CODE_BAD_DIR  = 16'h0003;

  localparam logic [3:0]  OFS_REQ_HEAD  = 4'h0;
  localparam logic [3:0]  OFS_REQ_TAIL  = 4'h4;
  localparam logic [3:0]  OFS_RSP_HEAD  = 4'h8;
  localparam logic [3:0]  OFS_RSP_TAIL  = 4'hc;

endpackage

// File: rtl/ring_idx_regs.sv
module ring_idx_regs
  import ring_chan_pkg::*;
#(
  parameter int unsigned IDXW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            host_wr,
  input  logic [3:0]      host_addr,
  input  logic [31:0]     host_wdata,
  input  logic            req_adv,
  input  logic            rsp_adv,
  output logic [IDXW-1:0] req_head,
  output logic [IDXW-1:0] req_tail,
  output logic [IDXW-1:0] rsp_head,
  output logic [IDXW-1:0] rsp_tail,
  output logic [31:0]     rdata
);

  logic            req_tail_en, rsp_head_en;
  logic [IDXW-1:0] req_head_d, rsp_tail_d;

  always_comb begin
    req_tail_en = host_wr && (host_addr == OFS_REQ_TAIL);
    rsp_head_en = host_wr && (host_addr == OFS_RSP_HEAD);
    req_head_d  = req_head + 1'b1;
    rsp_tail_d  = rsp_tail + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_head <= '0;
      req_tail <= '0;
      rsp_head <= '0;
      rsp_tail <= '0;
    end else begin
      if (req_adv)     req_head <= req_head_d;
      if (req_tail_en) req_tail <= host_wdata[IDXW-1:0];
      if (rsp_head_en) rsp_head <= host_wdata[IDXW-1:0];
      if (rsp_adv)     rsp_tail <= rsp_tail_d;
    end
  end

  always_comb begin
    rdata = '0;
    unique case (host_addr)
      OFS_REQ_HEAD: rdata[IDXW-1:0] = req_head;
      OFS_REQ_TAIL: rdata[IDXW-1:0] = req_tail;
      OFS_RSP_HEAD: rdata[IDXW-1:0] = rsp_head;
      OFS_RSP_TAIL: rdata[IDXW-1:0] = rsp_tail;
      default:      rdata = '0;
    endcase
  end

endmodule

// File: rtl/ring_seq.sv
module ring_seq
  import ring_chan_pkg::*;
#(
  parameter int unsigned IDXW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [IDXW-1:0] req_head,
  input  logic [IDXW-1:0] req_tail,
  input  logic [IDXW-1:0] rsp_head,
  input  logic [IDXW-1:0] rsp_tail,
  input  logic [15:0]     elem_id,
  input  logic [7:0]      elem_cmd,
  output logic            exec_valid,
  input  logic            exec_ready,
  output logic [15:0]     exec_id,
  output logic [7:0]      exec_cmd,
  input  logic            done_valid,
  input  logic [15:0]     done_code,
  output logic            rsp_valid,
  input  logic            rsp_ready,
  output logic [15:0]     rsp_id,
  output logic [15:0]     rsp_code,
  output logic            req_adv,
  output logic            rsp_adv,
  output logic            irq
);

  seq_st_e     st_q, st_d;
  logic [15:0] id_q, code_q, code_d;
  logic [7:0]  cmd_q;
  logic        cap_en, code_en, irq_d, irq_q;
  logic        pending, rsp_full, rsp_empty, want_rsp, force_irq;

  always_comb begin
    pending   = (req_head != req_tail);
    rsp_full  = ((rsp_tail + 1'b1) == rsp_head);
    rsp_empty = (rsp_tail == rsp_head);
    want_rsp  = cmd_q[CMD_WANT_RSP];
    force_irq = cmd_q[CMD_FORCE_IRQ];

    st_d       = st_q;
    cap_en     = 1'b0;
    code_en    = 1'b0;
    code_d     = done_code;
    exec_valid = 1'b0;
    rsp_valid  = 1'b0;
    req_adv    = 1'b0;
    rsp_adv    = 1'b0;
    irq_d      = 1'b0;

    unique case (st_q)
      ST_IDLE: begin
        if (pending) begin
          cap_en = 1'b1;
          if (elem_cmd[1:0] == DIR_ILLEGAL) begin
            code_en = 1'b1;
            code_d  = CODE_BAD_DIR;
            st_d    = ST_POST;
          end else begin
            st_d = ST_EXEC;
          end
        end
      end
      ST_EXEC: begin
        exec_valid = 1'b1;
        if (exec_ready) st_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (done_valid) begin
          code_en = 1'b1;
          st_d    = ST_POST;
        end
      end
      ST_POST: begin
        if (want_rsp) begin
          rsp_valid = !rsp_full;
          if (rsp_valid && rsp_ready) begin
            rsp_adv = 1'b1;
            req_adv = 1'b1;
            irq_d   = rsp_empty || force_irq;
            st_d    = ST_IDLE;
          end
        end else begin
          req_adv = 1'b1;
          irq_d   = force_irq;
          st_d    = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      id_q   <= '0;
      cmd_q  <= '0;
      code_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      irq_q <= irq_d;
      if (cap_en) begin
        id_q  <= elem_id;
        cmd_q <= elem_cmd;
      end
      if (code_en) code_q <= code_d;
    end
  end

  assign exec_id  = id_q;
  assign exec_cmd = cmd_q;
  assign rsp_id   = id_q;
  assign rsp_code = code_q;
  assign irq      = irq_q;

endmodule

// File: rtl/ring_chan_ctrl.sv
module ring_chan_ctrl
  import ring_chan_pkg::*;
#(
  parameter int unsigned RING_DEPTH = 16,
  localparam int unsigned IDXW = $clog2(RING_DEPTH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_wr,
  input  logic [3:0]      reg_addr,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  output logic [IDXW-1:0] ring_rd_idx,
  input  logic [15:0]     elem_id,
  input  logic [7:0]      elem_cmd,
  output logic            exec_valid,
  input  logic            exec_ready,
  output logic [15:0]     exec_id,
  output logic [7:0]      exec_cmd,
  input  logic            done_valid,
  input  logic [15:0]     done_code,
  output logic            rsp_valid,
  input  logic            rsp_ready,
  output logic [IDXW-1:0] rsp_slot,
  output logic [15:0]     rsp_id,
  output logic [15:0]     rsp_code,
  output logic            irq
);

  logic [IDXW-1:0] req_head, req_tail, rsp_head, rsp_tail;
  logic            req_adv, rsp_adv;

  ring_idx_regs #(.IDXW(IDXW)) regs_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_wr    (reg_wr),
    .host_addr  (reg_addr),
    .host_wdata (reg_wdata),
    .req_adv    (req_adv),
    .rsp_adv    (rsp_adv),
    .req_head   (req_head),
    .req_tail   (req_tail),
    .rsp_head   (rsp_head),
    .rsp_tail   (rsp_tail),
    .rdata      (reg_rdata)
  );

  ring_seq #(.IDXW(IDXW)) seq_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_head   (req_head),
    .req_tail   (req_tail),
    .rsp_head   (rsp_head),
    .rsp_tail   (rsp_tail),
    .elem_id    (elem_id),
    .elem_cmd   (elem_cmd),
    .exec_valid (exec_valid),
    .exec_ready (exec_ready),
    .exec_id    (exec_id),
    .exec_cmd   (exec_cmd),
    .done_valid (done_valid),
    .done_code  (done_code),
    .rsp_valid  (rsp_valid),
    .rsp_ready  (rsp_ready),
    .rsp_id     (rsp_id),
    .rsp_code   (rsp_code),
    .req_adv    (req_adv),
    .rsp_adv    (rsp_adv),
    .irq        (irq)
  );

  assign ring_rd_idx = req_head;
  assign rsp_slot    = rsp_tail;

endmodule

// File: rtl/ring_chan_ctrl_chk.sv
module ring_chan_ctrl_chk #(
  parameter int unsigned IDXW = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            exec_valid,
  input logic [7:0]      exec_cmd,
  input logic            rsp_valid,
  input logic            rsp_ready,
  input logic [IDXW-1:0] rsp_slot,
  input logic [15:0]     rsp_id,
  input logic [15:0]     rsp_code,
  input logic            irq,
  input logic [IDXW-1:0] req_head,
  input logic [IDXW-1:0] req_tail,
  input logic [IDXW-1:0] rsp_head,
  input logic [IDXW-1:0] rsp_tail
);

  logic [IDXW-1:0] rsp_tail_nx;
  assign rsp_tail_nx = rsp_tail + 1'b1;

  AST_REQ_HEAD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (req_head != $past(req_head)) |-> (req_head == IDXW'($past(req_head) + 1'b1))); // R5

  AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    (req_head != $past(req_head)) |-> ($past(req_head) != $past(req_tail))); // R4

  AST_RSP_NOT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_tail_nx != rsp_head)); // R10

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_id) && $stable(rsp_code) && $stable(rsp_slot))); // R11

  AST_NO_ILLEGAL_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    exec_valid |-> (exec_cmd[1:0] != 2'd3)); // R7

  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq); // R8

  AST_RSP_TAIL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_tail != $past(rsp_tail)) |-> $past(rsp_valid && rsp_ready)); // R6

endmodule

bind ring_chan_ctrl ring_chan_ctrl_chk #(.IDXW(IDXW)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .exec_valid (exec_valid),
  .exec_cmd   (exec_cmd),
  .rsp_valid  (rsp_valid),
  .rsp_ready  (rsp_ready),
  .rsp_slot   (rsp_slot),
  .rsp_id     (rsp_id),
  .rsp_code   (rsp_code),
  .irq        (irq),
  .req_head   (req_head),
  .req_tail   (req_tail),
  .rsp_head   (rsp_head),
  .rsp_tail   (rsp_tail)
);

// File: tb/ring_chan_ctrl_tb_top.sv
module ring_chan_ctrl_tb_top;

  localparam int DEPTH      = 4;
  localparam int IW         = $clog2(DEPTH);
  localparam int CLK_PERIOD = 10;
  localparam int NVEC       = 7;

  // {cmd[41:34], id[33:18], code[17:2], exp_rsp[1], exp_irq[0]}
  localparam logic [41:0] VEC [NVEC] = '{
    {8'h11, 16'h0101, 16'h0000, 1'b1, 1'b1},
    {8'h0A, 16'h0202, 16'h0000, 1'b0, 1'b0},
    {8'h91, 16'h0303, 16'h0005, 1'b1, 1'b1},
    {8'h82, 16'h0404, 16'h0000, 1'b0, 1'b1},
    {8'h13, 16'h0505, 16'h0003, 1'b1, 1'b1},
    {8'h03, 16'h0606, 16'h0003, 1'b0, 1'b0},
    {8'h1A, 16'h0707, 16'h00FF, 1'b1, 1'b1}
  };

  logic          clk, rst_n;
  logic          reg_wr;
  logic [3:0]    reg_addr;
  logic [31:0]   reg_wdata, reg_rdata;
  logic [IW-1:0] ring_rd_idx, rsp_slot;
  logic [15:0]   elem_id, exec_id, done_code, rsp_id, rsp_code;
  logic [7:0]    elem_cmd, exec_cmd;
  logic          exec_valid, exec_ready, done_valid, rsp_valid, rsp_ready, irq;

  logic [15:0] mem_id  [DEPTH];
  logic [7:0]  mem_cmd [DEPTH];
  assign elem_id  = mem_id[ring_rd_idx];
  assign elem_cmd = mem_cmd[ring_rd_idx];

  int checks = 0;
  int errors = 0;
  int q_tail = 0;
  int r_tail = 0;
  int r_head = 0;
  int cycles = 0;

  ring_chan_ctrl #(.RING_DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ring_rd_idx(ring_rd_idx),
    .elem_id(elem_id), .elem_cmd(elem_cmd), .exec_valid(exec_valid),
    .exec_ready(exec_ready), .exec_id(exec_id), .exec_cmd(exec_cmd),
    .done_valid(done_valid), .done_code(done_code), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_slot(rsp_slot), .rsp_id(rsp_id),
    .rsp_code(rsp_code), .irq(irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 20000) begin
      errors = errors + 1;
      $display("FAIL watchdog: run did not finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic host_wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr  = a;
    reg_wdata = d;
    reg_wr    = 1'b1;
    @(negedge clk);
    reg_wr    = 1'b0;
  endtask

  task automatic host_rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  // watches outputs for n cycles, accepting responses and counting pulses
  task automatic poll(input int n, input logic [15:0] eid, input logic [15:0] ecode,
                      output int nirq, output int nrsp, output int nexec);
    nirq = 0; nrsp = 0; nexec = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (irq) nirq++;
      if (exec_valid) nexec++;
      if (rsp_valid && !rsp_ready) begin
        nrsp++;
        chk(rsp_id == eid, "R6 rsp_id", 32'(rsp_id), 32'(eid));
        chk(rsp_code == ecode, "R6 rsp_code", 32'(rsp_code), 32'(ecode));
        chk(rsp_slot == IW'(r_tail), "R6 rsp_slot", 32'(rsp_slot), 32'(r_tail));
        rsp_ready = 1'b1;
      end else begin
        rsp_ready = 1'b0;
      end
    end
    rsp_ready = 1'b0;
  endtask

  task automatic run_req(input logic [7:0] cmd, input logic [15:0] id, input logic [15:0] code,
                         input bit exp_rsp, input bit exp_irq, input bit stalled);
    int nirq, nrsp, nexec;
    logic [31:0] rd;
    bit seen;
    mem_id[q_tail]  = id;
    mem_cmd[q_tail] = cmd;
    q_tail = (q_tail + 1) % DEPTH;
    host_wr(4'h4, 32'(q_tail));
    if (cmd[1:0] != 2'd3) begin
      seen = 1'b0;
      for (int i = 0; i < 20 && !seen; i++) begin
        @(negedge clk);
        seen = exec_valid;
      end
      chk(seen, "R4 exec_valid", 32'(seen), 1);
      chk(exec_id == id, "R4 exec_id", 32'(exec_id), 32'(id));
      chk(exec_cmd == cmd, "R7 exec_cmd passthrough", 32'(exec_cmd), 32'(cmd));
      exec_ready = 1'b1;
      @(negedge clk);
      exec_ready = 1'b0;
      done_valid = 1'b1;
      done_code  = code;
      @(negedge clk);
      done_valid = 1'b0;
    end
    poll(12, id, code, nirq, nrsp, nexec);
    if (cmd[1:0] == 2'd3) chk(nexec == 0, "R7 illegal not issued", 32'(nexec), 0);
    if (stalled) begin
      chk(nrsp == 0, "R10 no post while full", 32'(nrsp), 0);
      chk(nirq == 0, "R10 no irq while full", 32'(nirq), 0);
      host_rd(4'h0, rd);
      chk(rd == 32'((q_tail + DEPTH - 1) % DEPTH), "R10 head held", rd, 32'((q_tail + DEPTH - 1) % DEPTH));
    end else begin
      chk(nrsp == int'(exp_rsp), "R6 response count", 32'(nrsp), 32'(exp_rsp));
      chk(nirq == int'(exp_irq), "R8/R9 irq count", 32'(nirq), 32'(exp_irq));
      if (exp_rsp) r_tail = (r_tail + 1) % DEPTH;
      host_rd(4'h0, rd);
      chk(rd == 32'(q_tail), "R5 req head advance", rd, 32'(q_tail));
      host_rd(4'hc, rd);
      chk(rd == 32'(r_tail), "R6 rsp tail", rd, 32'(r_tail));
    end
  endtask

  task automatic drain();
    r_head = r_tail;
    host_wr(4'h8, 32'(r_head));
  endtask

  initial begin
    logic [31:0] rd;
    int nirq, nrsp, nexec;
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    exec_ready = 1'b0; done_valid = 1'b0; done_code = '0; rsp_ready = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin mem_id[i] = '0; mem_cmd[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      host_rd(4'(a * 4), rd);
      chk(rd == 0, "R1 index reset", rd, 0);
    end
    chk(!exec_valid && !rsp_valid && !irq, "R1 outputs idle", {29'd0, exec_valid, rsp_valid, irq}, 0);

    // R2 masking and map, R3 ignored writes
    host_wr(4'h8, 32'hFFFF_FFF0);
    host_rd(4'h8, rd);
    chk(rd == 0, "R2 rsp head masked", rd, 0);
    host_wr(4'h8, 32'd5);
    host_rd(4'h8, rd);
    chk(rd == 1, "R2 rsp head map", rd, 1);
    host_wr(4'h8, 32'd0);
    host_wr(4'h0, 32'd2);
    host_wr(4'hc, 32'd3);
    host_rd(4'h0, rd);
    chk(rd == 0, "R3 req head write ignored", rd, 0);
    host_rd(4'hc, rd);
    chk(rd == 0, "R3 rsp tail write ignored", rd, 0);
    chk(!exec_valid && !rsp_valid, "R3 no activity", {30'd0, exec_valid, rsp_valid}, 0);

    // vector table, responses drained after each so the ring starts empty
    for (int v = 0; v < NVEC; v++) begin
      run_req(VEC[v][41:34], VEC[v][33:18], VEC[v][17:2], VEC[v][1], VEC[v][0], 1'b0);
      drain();
    end

    // R8 posting into a non-empty ring gives no pulse
    run_req(8'h11, 16'h0A01, 16'h0000, 1'b1, 1'b1, 1'b0);
    run_req(8'h11, 16'h0A02, 16'h0000, 1'b1, 1'b0, 1'b0);
    // R9 force into non-empty ring still pulses
    run_req(8'h91, 16'h0A03, 16'h0000, 1'b1, 1'b1, 1'b0);
    // R10 ring now holds DEPTH-1 entries: next response stalls
    run_req(8'h12, 16'h0A04, 16'h0009, 1'b1, 1'b0, 1'b1);
    r_head = (r_head + 1) % DEPTH;
    host_wr(4'h8, 32'(r_head));
    poll(12, 16'h0A04, 16'h0009, nirq, nrsp, nexec);
    chk(nrsp == 1, "R10 post resumes", 32'(nrsp), 1);
    chk(nirq == 0, "R10 no irq non-empty", 32'(nirq), 0);
    r_tail = (r_tail + 1) % DEPTH;
    host_rd(4'h0, rd);
    chk(rd == 32'(q_tail), "R10 head advance after resume", rd, 32'(q_tail));
    host_rd(4'hc, rd);
    chk(rd == 32'(r_tail), "R6 tail after resume", rd, 32'(r_tail));
    drain();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule